// File: doc/BRIEF.md
# Nine-bit flagged frame packer for a three-wire display link

The block sits in front of the serial shifter of a three-wire display link, where no separate pin tells the panel whether a byte is a command or pixel data. Every byte offered at the input carries a command/data tag. The block turns it into a 9-bit frame: a flag bit, then the eight payload bits. It packs these frames back to back into a stream of 8-bit words that the shifter can send unchanged.

Since 9 is not a multiple of 8, a frame usually straddles two output words. At the end of a transaction the last word may be only partly filled. A flush request closes the stream. While the bit position is not on a word boundary, the block appends whole filler command frames that carry the write-RAM opcode (0x5C), which the panel tolerates. The last output word of a flush is marked, so the shifter knows where to release chip select. Input and output each use a valid/ready handshake.

Top module: `ninebit_packer`

## Requirements
- R1: Each accepted byte becomes a 9-bit frame sent flag first and then the payload MSB first. The flag is 0 for a command byte (`in_is_cmd`=1) and 1 for a data byte (`in_is_cmd`=0). A lone command 0xA5 after reset therefore yields a first output word of 0x52.
- R2: Frames are packed with no gaps. Each output word is filled from bit 7 down to bit 0, and eight frames yield exactly nine words, none of them marked last.
- R3: After a flush with k leftover bits (1..7), the block appends filler frames {flag 0, opcode 0x5C} until the stream reaches a word boundary. Any run of 1 to 7 frames followed by a flush therefore produces exactly nine words.
- R4: `out_last` is high on the final word produced by a flush and low on every other word.
- R5: A flush while no partial bits are held produces no word and no last marker.
- R6: While a word is offered and not taken (`out_valid`=1, `out_ready`=0), `in_ready` is low, and `out_byte` and `out_last` hold their values until the word is accepted.
- R7: From the cycle after a flush request until the padding is complete, `in_ready` is low.
- R8: Synchronous reset clears the output and the partial word. After reset `out_valid` is 0, `in_ready` is 1, and the next frame starts at bit 7 of a fresh word, even if reset arrived in the middle of a word.
- R9: A frame accepted in the same cycle as a flush pulse is packed before the padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block can take the input byte |
| in_is_cmd | input | 1 | 1: byte is a command, 0: byte is data |
| in_byte | input | PAYLOAD_W | Payload byte |
| flush | input | 1 | One-cycle request to close the stream on a word boundary |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word |
| out_byte | output | PAYLOAD_W | Packed output word, first bit to send in bit 7 |
| out_last | output | 1 | Word is the final one of a flush |

## Verification
The assertions check the following on every cycle:
- the input is blocked during output back-pressure and while a flush is pending;
- an offered word stays stable until it is taken;
- the partial-bit count never passes one full word;
- a pending flush clears only on a word boundary, and a last-marked word only appears on that boundary.

The bench scenarios show what only the bit content can prove:
- the flag polarity and payload order;
- the exact filler frames and how many of them a flush adds;
- the nine-word result for every leftover width;
- that flush and reset leave no stale bits behind.

// File: rtl/npk_pkg.sv
package npk_pkg;

    // flag bit that leads each 9-bit frame
    localparam logic FLAG_CMD  = 1'b0;
    localparam logic FLAG_DATA = 1'b1;

    // default opcode used for alignment padding
    localparam logic [7:0] DEFAULT_FILLER = 8'h5C;

    // which source feeds the output word in a given cycle
    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_INPUT,
        SRC_PAD,
        SRC_DRAIN
    } npk_src_e;

    function automatic logic flag_for(input logic is_cmd);
        return is_cmd ? FLAG_CMD : FLAG_DATA;
    endfunction

endpackage

// File: rtl/npk_merge.sv
// Combines the held partial bits with one new frame.
// The result is one completed word and the new remainder.
module npk_merge #(
    parameter int W      = 8,
    parameter int FILL_W = 4
) (
    input  logic [W-1:0]      acc,
    input  logic [FILL_W-1:0] fill,
    input  logic [W:0]        frame,
    output logic [W-1:0]      word,
    output logic [W-1:0]      rem
);
    localparam int SPAN = 2 * W;

    logic [SPAN-1:0] wide;

    always_comb begin
        // held bits sit MSB-aligned; the frame starts right after them
        wide = {acc, {W{1'b0}}} | ({frame, {(W-1){1'b0}}} >> fill);
        word = wide[SPAN-1 -: W];
        rem  = wide[W-1:0];
    end
endmodule

// File: rtl/npk_out_stage.sv
// Single output word register with a valid/ready handshake.
module npk_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         ld_last,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_last,
    output logic         slot_free
);
    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_last  <= ld_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/npk_flush_ctrl.sv
// Tracks an outstanding flush until the stream reaches a word boundary.
module npk_flush_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic fill_empty,
    input  logic drain,
    output logic pending
);
    logic done;

    assign done = pending && (fill_empty || drain);

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= flush || (pending && !done);
    end

    // R3
    flush_align_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> fill_empty);
endmodule

// File: rtl/ninebit_packer.sv
module ninebit_packer #(
    parameter int                   PAYLOAD_W = 8,
    parameter logic [PAYLOAD_W-1:0] FILLER_OP = npk_pkg::DEFAULT_FILLER
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_is_cmd,
    input  logic [PAYLOAD_W-1:0] in_byte,
    input  logic                 flush,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PAYLOAD_W-1:0] out_byte,
    output logic                 out_last
);
    import npk_pkg::*;

    localparam int FRAME_W = PAYLOAD_W + 1;
    localparam int FILL_W  = $clog2(PAYLOAD_W + 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(PAYLOAD_W);

    logic [PAYLOAD_W-1:0] acc;
    logic [FILL_W-1:0]    fill;
    logic                 slot_free;
    logic                 pending;
    npk_src_e             src;
    logic [FRAME_W-1:0]   frame;
    logic [PAYLOAD_W-1:0] word;
    logic [PAYLOAD_W-1:0] rem;
    logic                 load;
    logic [PAYLOAD_W-1:0] ld_data;
    logic                 ld_last;
    logic                 drain;

    assign in_ready = slot_free && (fill != FULL) && !pending;

    // source priority: full word first, then new input, then padding
    always_comb begin
        if (slot_free && fill == FULL)
            src = SRC_DRAIN;
        else if (in_valid && in_ready)
            src = SRC_INPUT;
        else if (slot_free && pending && fill != '0)
            src = SRC_PAD;
        else
            src = SRC_IDLE;
    end

    assign frame = (src == SRC_PAD) ? {FLAG_CMD, FILLER_OP}
                                    : {flag_for(in_is_cmd), in_byte};
    assign drain   = (src == SRC_DRAIN);
    assign load    = (src != SRC_IDLE);
    assign ld_data = drain ? acc : word;
    assign ld_last = drain && pending;

    npk_merge #(.W(PAYLOAD_W), .FILL_W(FILL_W)) merge_i (
        .acc   (acc),
        .fill  (fill),
        .frame (frame),
        .word  (word),
        .rem   (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            fill <= '0;
        end else begin
            case (src)
                SRC_INPUT, SRC_PAD: begin
                    acc  <= rem;
                    fill <= fill + 1'b1;
                end
                SRC_DRAIN: begin
                    acc  <= '0;
                    fill <= '0;
                end
                default: ;
            endcase
        end
    end

    npk_out_stage #(.W(PAYLOAD_W)) out_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_data   (ld_data),
        .ld_last   (ld_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_byte),
        .out_last  (out_last),
        .slot_free (slot_free)
    );

    npk_flush_ctrl flush_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .fill_empty (fill == '0),
        .drain      (drain),
        .pending    (pending)
    );

    // R6
    in_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7
    pend_block_chk: assert property (@(posedge clk) disable iff (rst)
        pending |-> !in_ready);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);

    // R4
    last_align_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (fill == '0));
endmodule

// File: tb/ninebit_packer_tb_top.sv
`timescale 1ns/100ps
module ninebit_packer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_is_cmd = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       flush = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_byte;
    logic       out_last;

    always #2.5 clk = ~clk;

    ninebit_packer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_cmd(in_is_cmd), .in_byte(in_byte), .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .out_last(out_last)
    );

    typedef struct packed { logic [7:0] b; logic l; } word_t;

    word_t got_q[$];
    word_t exp_q[$];
    bit    mbits[$];
    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    wd = 0;
    bit    stall_mode = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model of the packed bit stream
    task automatic model_frame(input bit flg, input logic [7:0] b);
        mbits.push_back(flg);
        for (int i = 7; i >= 0; i--) mbits.push_back(b[i]);
        while (mbits.size() >= 8) begin
            word_t w;
            w.l = 1'b0;
            for (int i = 7; i >= 0; i--) w.b[i] = mbits.pop_front();
            exp_q.push_back(w);
        end
    endtask

    task automatic model_flush();
        word_t t;
        if (mbits.size() == 0) return;
        while (mbits.size() != 0) model_frame(1'b0, 8'h5C);
        t = exp_q.pop_back();
        t.l = 1'b1;
        exp_q.push_back(t);
    endtask

    // output side: drive ready, then record the handshake due at the next edge
    always @(negedge clk) begin
        cyc++;
        out_ready = stall_mode ? (cyc % 3 == 1) : 1'b1;
        #1;
        if (rst) got_q.delete();
        else begin
            if (out_valid && !out_ready)
                chk(!in_ready, "R6", "in_ready during stall", int'(in_ready), 0);
            if (out_valid && out_ready) got_q.push_back({out_byte, out_last});
        end
    end

    // R6: an offered word holds until it is taken
    logic       prev_stall = 1'b0;
    logic [7:0] prev_b = 8'h00;
    logic       prev_l = 1'b0;
    always @(negedge clk) begin
        #1.5;
        if (!rst && prev_stall)
            chk(out_valid && out_byte == prev_b && out_last == prev_l, "R6",
                "held word", int'(out_byte), int'(prev_b));
        prev_stall = !rst && out_valid && !out_ready;
        prev_b = out_byte;
        prev_l = out_last;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; flush = 1'b0;
        repeat (3) @(negedge clk);
        mbits.delete();
        exp_q.delete();
        rst = 1'b0;
    endtask

    task automatic send(input bit is_cmd, input logic [7:0] b, input bit with_flush);
        @(negedge clk);
        in_valid = 1'b1; in_is_cmd = is_cmd; in_byte = b;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        if (with_flush) flush = 1'b1;
        @(posedge clk);
        model_frame(is_cmd ? 1'b0 : 1'b1, b);
        if (with_flush) model_flush();
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        model_flush();
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic settle();
        repeat (100) @(negedge clk);
        #2;
    endtask

    task automatic compare(input string req);
        int n;
        chk(got_q.size() == exp_q.size(), req, "word count", got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            chk(got_q[i].b == exp_q[i].b, req, "word value", int'(got_q[i].b), int'(exp_q[i].b));
            chk(got_q[i].l == exp_q[i].l, req, "last flag", int'(got_q[i].l), int'(exp_q[i].l));
        end
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(!out_valid, "R8", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready, "R8", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_single();
        send(1'b1, 8'hA5, 1'b0);
        do_flush();
        settle();
        chk(got_q.size() == 9, "R3", "padded length", got_q.size(), 9);
        if (got_q.size() >= 9) begin
            chk(got_q[0].b == 8'h52, "R1", "first word", int'(got_q[0].b), 8'h52);
            chk(got_q[8].l == 1'b1, "R4", "last marker", int'(got_q[8].l), 1);
        end
        compare("R1");
    endtask

    task automatic t_eight();
        for (int i = 0; i < 8; i++) send(1'b0, 8'h30 + 8'(i), 1'b0);
        settle();
        chk(got_q.size() == 9, "R2", "eight frames", got_q.size(), 9);
        compare("R2");
        do_flush();
        settle();
        chk(got_q.size() == 0, "R5", "empty flush words", got_q.size(), 0);
        compare("R5");
    endtask

    task automatic t_burst();
        send(1'b1, 8'hAF, 1'b0);
        for (int i = 0; i < 14; i++) send(1'b0, 8'(i * 17), 1'b0);
        do_flush();
        settle();
        compare("R3");
    endtask

    task automatic t_residue();
        for (int k = 1; k <= 7; k++) begin
            for (int j = 0; j < k; j++) send(j[0], 8'hC3 ^ 8'(j), 1'b0);
            do_flush();
            settle();
            chk(got_q.size() == 9, "R3", "words for residue", got_q.size(), 9);
            compare("R4");
        end
    endtask

    task automatic t_stall();
        stall_mode = 1'b1;
        for (int i = 0; i < 20; i++) send(i % 4 == 0, 8'h9D + 8'(i * 5), 1'b0);
        do_flush();
        settle();
        compare("R6");
        stall_mode = 1'b0;
    endtask

    task automatic t_pend();
        send(1'b0, 8'h11, 1'b0);
        @(negedge clk);
        flush = 1'b1;
        model_flush();
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b1; in_is_cmd = 1'b0; in_byte = 8'h22;
        #1;
        chk(!in_ready, "R7", "in_ready while padding", int'(in_ready), 0);
        in_valid = 1'b0;
        settle();
        compare("R7");
    endtask

    task automatic t_same();
        send(1'b0, 8'h5A, 1'b1);
        settle();
        chk(got_q.size() == 9, "R9", "frame plus padding", got_q.size(), 9);
        compare("R9");
    endtask

    task automatic t_midreset();
        send(1'b0, 8'h01, 1'b0);
        send(1'b0, 8'h02, 1'b0);
        send(1'b1, 8'h03, 1'b0);
        do_reset();
        send(1'b1, 8'hFF, 1'b0);
        do_flush();
        settle();
        if (got_q.size() > 0)
            chk(got_q[0].b == 8'h7F, "R8", "first word after reset", int'(got_q[0].b), 8'h7F);
        else
            chk(1'b0, "R8", "first word after reset", 0, 8'h7F);
        compare("R8");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_single();
        t_eight();
        t_burst();
        t_residue();
        t_stall();
        t_pend();
        t_same();
        t_midreset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule